// File: doc/BRIEF.md
# Linear Flash Card Byte-Steering Decoder

This block is the card-side glue of a removable linear flash card. The host presents two active-low byte enables, an attribute-plane select, output and write strobes, and a byte address. From these the block chooses which byte-wide flash device(s) are selected, routes bytes between the 16-bit host bus and the separate even-byte and odd-byte device buses, and reaches a small attribute memory that holds only even bytes. The flash array is built from pairs of byte-wide devices. In each pair one device serves the even byte and the other serves the odd byte.

The block supports four access shapes. A 16-bit host uses word access and odd-only access. An 8-bit host uses byte access, where address bit 0 chooses which byte appears on the low data lane. A write-protect input locks out every flash write. Addresses beyond the populated pairs wrap at the next power-of-two boundary, so a card with a size that is not a power of two never aliases a missing pair onto a real one.

The block is purely combinational. It holds no state, and the host's own strobe timing defines each access.

Top module: `flash_card_steer`

## Requirements
- R1: With both byte enables high (standby), both host lane enables are low, every flash chip select is high and the attribute select is high.
- R2: Byte mode is byte enable 1 low and byte enable 2 high. On a read, the low host lane carries the even byte when address bit 0 is 0 and the odd byte when it is 1. The high lane is not driven.
- R3: Word mode is both byte enables low. Address bit 0 is ignored. The low lane carries the even byte on host bits 7:0 and the high lane carries the odd byte on host bits 15:8.
- R4: Odd-only mode is byte enable 1 high and byte enable 2 low. The high lane carries the odd byte and the low lane is not driven.
- R5: A host lane is driven only while the output strobe is low and the write strobe is high, and only when the mode uses that lane. A write needs the output strobe high.
- R6: On a flash write, the even device takes host bits 7:0. The odd device takes host bits 15:8 in word and odd-only modes, and host bits 7:0 in byte mode with address bit 0 set. Only the devices the mode uses are selected.
- R7: The pair index is the address field just above the per-device word address (bits DEV_AW+1 upward). Only the addressed pair's selects go low. An index at or above NUM_PAIRS selects no device and reads as zero in the bench's device model.
- R8: Address bits above the pair-index field, which is ceil(log2(NUM_PAIRS)) bits wide, are ignored, so the card wraps at that power-of-two boundary.
- R9: With the attribute select low, no flash chip select goes low. Even bytes come from the attribute memory, and any odd-byte lane that is read returns 0xFF.
- R10: Attribute writes store host bits 7:0 when the access includes the even byte. Odd-only and odd byte-mode attribute writes change nothing and never pulse the attribute write strobe.
- R11: While write-protect is high, the flash write strobe stays high and the flash contents do not change.
- R12: The wait output is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostCe1N | input | 1 | Even-byte enable, active low |
| hostCe2N | input | 1 | Odd-byte enable, active low |
| hostRegN | input | 1 | Attribute-plane select, active low |
| hostOeN | input | 1 | Output (read) strobe, active low |
| hostWeN | input | 1 | Write strobe, active low |
| hostAddr | input | HOST_AW | Host byte address, bit 0 is the byte select |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Read data toward the host |
| hostLaneLoEn | output | 1 | Drive enable for host bits 7:0 |
| hostLaneHiEn | output | 1 | Drive enable for host bits 15:8 |
| hostWaitN | output | 1 | Wait request, held high |
| wrProtect | input | 1 | Write-protect switch, high locks flash writes |
| devAddr | output | DEV_AW | Word address inside each flash device |
| devCsLoN | output | NUM_PAIRS | Even-device chip selects, active low |
| devCsHiN | output | NUM_PAIRS | Odd-device chip selects, active low |
| devOeN | output | 1 | Shared flash read strobe, active low |
| devWeN | output | 1 | Shared flash write strobe, active low |
| devWrLo | output | 8 | Write data to even devices |
| devWrHi | output | 8 | Write data to odd devices |
| devRdLo | input | 8 | Read data from the selected even device |
| devRdHi | input | 8 | Read data from the selected odd device |
| attrCsN | output | 1 | Attribute memory select, active low |
| attrWeN | output | 1 | Attribute memory write strobe, active low |
| attrAddr | output | ATTR_AW | Attribute memory even-byte index |
| attrWrData | output | 8 | Attribute memory write data |
| attrRdData | input | 8 | Attribute memory read data |

## Verification
The inline assertions assume the host changes address, data and strobes together and lets them settle before the outputs are judged. They also assume the read and write strobes are never treated as both active. The stimulus changes inputs only on the falling clock edge and holds them for a full cycle, and it samples shortly after each change. Writes keep the output strobe high and hold the write strobe low across one rising edge, where the behavioural device models store data. With these limits a strobe transition never straddles a sample point. An overlap of read and write strobes is applied only to check that nothing is driven.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE,
    MODE_BYTE,
    MODE_WORD,
    MODE_ODD
  } accMode_e;

  // strobes passed from the decoder to the steering datapath
  typedef struct packed {
    logic laneLoEn;   // host bits 7:0 driven
    logic laneHiEn;   // host bits 15:8 driven
    logic loFromOdd;  // low host lane carries the odd byte
    logic useEven;    // access touches the even byte
    logic useOdd;     // access touches the odd byte
    logic attrPlane;  // attribute plane selected
    logic rdCycle;    // read in progress
    logic wrCycle;    // write in progress
  } strobe_t;

endpackage

// File: rtl/fcs_ctrl.sv
module fcs_ctrl
  import fcs_pkg::*;
(
  input  logic    ce1N,
  input  logic    ce2N,
  input  logic    regN,
  input  logic    oeN,
  input  logic    weN,
  input  logic    addrLsb,
  output strobe_t strobes
);

  accMode_e mode;
  logic     active;

  always_comb begin
    unique case ({ce2N, ce1N})
      2'b11:   mode = MODE_IDLE;
      2'b10:   mode = MODE_BYTE;
      2'b00:   mode = MODE_WORD;
      default: mode = MODE_ODD;
    endcase
  end

  assign active = (mode != MODE_IDLE);

  always_comb begin
    strobes           = '0;
    strobes.attrPlane = !regN;
    strobes.rdCycle   = active && !oeN && weN;
    strobes.wrCycle   = active && !weN && oeN;
    strobes.loFromOdd = (mode == MODE_BYTE) && addrLsb;
    strobes.useEven   = (mode == MODE_WORD) || ((mode == MODE_BYTE) && !addrLsb);
    strobes.useOdd    = (mode == MODE_WORD) || (mode == MODE_ODD) ||
                        ((mode == MODE_BYTE) && addrLsb);
    strobes.laneLoEn  = strobes.rdCycle && ((mode == MODE_BYTE) || (mode == MODE_WORD));
    strobes.laneHiEn  = strobes.rdCycle && ((mode == MODE_WORD) || (mode == MODE_ODD));
  end

  always_comb begin
    if (ce1N && ce2N)
      assert_standby_quiet_R1: assert (!strobes.laneLoEn && !strobes.laneHiEn &&
                                       !strobes.useEven && !strobes.useOdd)
        else $error("standby left a lane or byte active");
    if (strobes.laneLoEn || strobes.laneHiEn)
      assert_lane_gate_R5: assert (!oeN && weN)
        else $error("lane driven outside a read strobe");
    if (!ce1N && !ce2N && !oeN && weN)
      assert_word_both_lanes_R3: assert (strobes.laneLoEn && strobes.laneHiEn && !strobes.loFromOdd)
        else $error("word read did not drive both lanes straight");
    if (ce1N && !ce2N)
      assert_odd_only_R4: assert (!strobes.laneLoEn && !strobes.useEven)
        else $error("odd-only access touched the low lane");
  end

endmodule

// File: rtl/fcs_path.sv
module fcs_path
  import fcs_pkg::*;
#(
  parameter int HOST_AW   = 26,
  parameter int DEV_AW    = 17,
  parameter int NUM_PAIRS = 10,
  parameter int ATTR_AW   = 10
) (
  input  strobe_t              strobes,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic [15:0]          hostWrData,
  input  logic                 wrProtect,
  output logic [15:0]          hostRdData,
  output logic [DEV_AW-1:0]    devAddr,
  output logic [NUM_PAIRS-1:0] devCsLoN,
  output logic [NUM_PAIRS-1:0] devCsHiN,
  output logic                 devOeN,
  output logic                 devWeN,
  output logic [7:0]           devWrLo,
  output logic [7:0]           devWrHi,
  input  logic [7:0]           devRdLo,
  input  logic [7:0]           devRdHi,
  output logic                 attrCsN,
  output logic                 attrWeN,
  output logic [ATTR_AW-1:0]   attrAddr,
  output logic [7:0]           attrWrData,
  input  logic [7:0]           attrRdData
);

  localparam int PAIR_W  = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;
  localparam int PAIR_LO = DEV_AW + 1;
  localparam int USED_W  = PAIR_LO + PAIR_W;
  localparam logic [7:0] ODD_ATTR_FILL = 8'hFF;

  logic [PAIR_W-1:0] pairIdx;
  logic              pairHit;
  logic              flashAcc;
  logic              unusedAddr;

  assign pairIdx    = hostAddr[PAIR_LO +: PAIR_W];
  assign pairHit    = ({1'b0, pairIdx} < (PAIR_W + 1)'(NUM_PAIRS));
  assign flashAcc   = !strobes.attrPlane;
  assign unusedAddr = ^{hostAddr[HOST_AW-1:USED_W], hostAddr[0]};

  assign devAddr  = hostAddr[DEV_AW:1];
  assign attrAddr = hostAddr[ATTR_AW:1];

  for (genvar gi = 0; gi < NUM_PAIRS; gi++) begin : g_pair
    logic pairSel;
    assign pairSel      = flashAcc && pairHit && (pairIdx == PAIR_W'(gi));
    assign devCsLoN[gi] = !(pairSel && strobes.useEven);
    assign devCsHiN[gi] = !(pairSel && strobes.useOdd);
  end

  assign devOeN  = !(strobes.rdCycle && flashAcc);
  assign devWeN  = !(strobes.wrCycle && flashAcc && !wrProtect);
  assign attrCsN = !(strobes.attrPlane && strobes.useEven);
  assign attrWeN = !(strobes.wrCycle && strobes.attrPlane && strobes.useEven);

  assign devWrLo    = hostWrData[7:0];
  assign devWrHi    = strobes.loFromOdd ? hostWrData[7:0] : hostWrData[15:8];
  assign attrWrData = hostWrData[7:0];

  always_comb begin
    logic [7:0] evenByte;
    logic [7:0] oddByte;
    evenByte   = strobes.attrPlane ? attrRdData : devRdLo;
    oddByte    = strobes.attrPlane ? ODD_ATTR_FILL : devRdHi;
    hostRdData = '0;
    if (strobes.laneLoEn) hostRdData[7:0]  = strobes.loFromOdd ? oddByte : evenByte;
    if (strobes.laneHiEn) hostRdData[15:8] = oddByte;
  end

  always_comb begin
    assert_cs_onehot_R7: assert ($onehot0(~devCsLoN) && $onehot0(~devCsHiN))
      else $error("more than one pair selected");
    if (wrProtect)
      assert_wp_lock_R11: assert (devWeN)
        else $error("flash write strobe under write protect");
    if (strobes.attrPlane)
      assert_attr_isolation_R9: assert ((&devCsLoN) && (&devCsHiN))
        else $error("flash selected during attribute access");
    if (!attrWeN)
      assert_attr_even_only_R10: assert (!attrCsN && !strobes.loFromOdd)
        else $error("attribute write on an odd byte");
  end

endmodule

// File: rtl/flash_card_steer.sv
module flash_card_steer
  import fcs_pkg::*;
#(
  parameter int HOST_AW   = 26,
  parameter int DEV_AW    = 17,
  parameter int NUM_PAIRS = 10,
  parameter int ATTR_AW   = 10
) (
  input  logic                 hostCe1N,
  input  logic                 hostCe2N,
  input  logic                 hostRegN,
  input  logic                 hostOeN,
  input  logic                 hostWeN,
  input  logic [HOST_AW-1:0]   hostAddr,
  input  logic [15:0]          hostWrData,
  output logic [15:0]          hostRdData,
  output logic                 hostLaneLoEn,
  output logic                 hostLaneHiEn,
  output logic                 hostWaitN,
  input  logic                 wrProtect,
  output logic [DEV_AW-1:0]    devAddr,
  output logic [NUM_PAIRS-1:0] devCsLoN,
  output logic [NUM_PAIRS-1:0] devCsHiN,
  output logic                 devOeN,
  output logic                 devWeN,
  output logic [7:0]           devWrLo,
  output logic [7:0]           devWrHi,
  input  logic [7:0]           devRdLo,
  input  logic [7:0]           devRdHi,
  output logic                 attrCsN,
  output logic                 attrWeN,
  output logic [ATTR_AW-1:0]   attrAddr,
  output logic [7:0]           attrWrData,
  input  logic [7:0]           attrRdData
);

  strobe_t strobes;

  fcs_ctrl ctrl_i (
    .ce1N    (hostCe1N),
    .ce2N    (hostCe2N),
    .regN    (hostRegN),
    .oeN     (hostOeN),
    .weN     (hostWeN),
    .addrLsb (hostAddr[0]),
    .strobes (strobes)
  );

  fcs_path #(
    .HOST_AW   (HOST_AW),
    .DEV_AW    (DEV_AW),
    .NUM_PAIRS (NUM_PAIRS),
    .ATTR_AW   (ATTR_AW)
  ) path_i (
    .strobes    (strobes),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .wrProtect  (wrProtect),
    .hostRdData (hostRdData),
    .devAddr    (devAddr),
    .devCsLoN   (devCsLoN),
    .devCsHiN   (devCsHiN),
    .devOeN     (devOeN),
    .devWeN     (devWeN),
    .devWrLo    (devWrLo),
    .devWrHi    (devWrHi),
    .devRdLo    (devRdLo),
    .devRdHi    (devRdHi),
    .attrCsN    (attrCsN),
    .attrWeN    (attrWeN),
    .attrAddr   (attrAddr),
    .attrWrData (attrWrData),
    .attrRdData (attrRdData)
  );

  assign hostLaneLoEn = strobes.laneLoEn;
  assign hostLaneHiEn = strobes.laneHiEn;
  assign hostWaitN    = 1'b1;  // R12: never stretches a cycle

endmodule

// File: tb/flash_card_steer_tb.sv
`timescale 1ns/1ps
module flash_card_steer_tb_top;

  localparam int HOST_AW = 7;
  localparam int DEV_AW  = 2;
  localparam int NP      = 5;
  localparam int PW      = 3;
  localparam int ATTR_AW = 4;
  localparam int DEPTH   = 1 << DEV_AW;
  localparam int ADEPTH  = 1 << ATTR_AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               ce1N = 1'b1, ce2N = 1'b1, regN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic               wp = 1'b0;
  logic [HOST_AW-1:0] addr = '0;
  logic [15:0]        wrData = '0;
  logic [15:0]        rdData;
  logic               laneLo, laneHi, waitN;
  logic [DEV_AW-1:0]  devAddr;
  logic [NP-1:0]      csLoN, csHiN;
  logic               devOeN, devWeN;
  logic [7:0]         devWrLo, devWrHi, devRdLo, devRdHi;
  logic               attrCsN, attrWeN;
  logic [ATTR_AW-1:0] attrAddr;
  logic [7:0]         attrWr, attrRd;

  flash_card_steer #(.HOST_AW(HOST_AW), .DEV_AW(DEV_AW), .NUM_PAIRS(NP), .ATTR_AW(ATTR_AW)) dut_i (
    .hostCe1N(ce1N), .hostCe2N(ce2N), .hostRegN(regN), .hostOeN(oeN), .hostWeN(weN),
    .hostAddr(addr), .hostWrData(wrData), .hostRdData(rdData),
    .hostLaneLoEn(laneLo), .hostLaneHiEn(laneHi), .hostWaitN(waitN), .wrProtect(wp),
    .devAddr(devAddr), .devCsLoN(csLoN), .devCsHiN(csHiN), .devOeN(devOeN), .devWeN(devWeN),
    .devWrLo(devWrLo), .devWrHi(devWrHi), .devRdLo(devRdLo), .devRdHi(devRdHi),
    .attrCsN(attrCsN), .attrWeN(attrWeN), .attrAddr(attrAddr), .attrWrData(attrWr),
    .attrRdData(attrRd)
  );

  // behavioural devices
  logic [7:0] memLo [NP*DEPTH];
  logic [7:0] memHi [NP*DEPTH];
  logic [7:0] memAttr [ADEPTH];
  // bench shadow of expected contents
  logic [7:0] shLo [NP*DEPTH];
  logic [7:0] shHi [NP*DEPTH];
  logic [7:0] shAttr [ADEPTH];

  function automatic logic [7:0] seedFlash(int p, int w, int side);
    return 8'((p * 37 + w * 5 + side * 101 + 17) & 255);
  endfunction

  initial begin
    for (int p = 0; p < NP; p++)
      for (int w = 0; w < DEPTH; w++) begin
        memLo[p*DEPTH+w] = seedFlash(p, w, 0); shLo[p*DEPTH+w] = seedFlash(p, w, 0);
        memHi[p*DEPTH+w] = seedFlash(p, w, 1); shHi[p*DEPTH+w] = seedFlash(p, w, 1);
      end
    for (int i = 0; i < ADEPTH; i++) begin
      memAttr[i] = 8'((i * 3 + 7) & 255); shAttr[i] = 8'((i * 3 + 7) & 255);
    end
  end

  always_comb begin
    devRdLo = 8'h00;
    devRdHi = 8'h00;
    for (int p = 0; p < NP; p++) begin
      if (!csLoN[p]) devRdLo = memLo[p*DEPTH+int'(devAddr)];
      if (!csHiN[p]) devRdHi = memHi[p*DEPTH+int'(devAddr)];
    end
    attrRd = attrCsN ? 8'h00 : memAttr[attrAddr];
  end

  always @(posedge clk) begin
    if (!devWeN)
      for (int p = 0; p < NP; p++) begin
        if (!csLoN[p]) memLo[p*DEPTH+int'(devAddr)] <= devWrLo;
        if (!csHiN[p]) memHi[p*DEPTH+int'(devAddr)] <= devWrHi;
      end
    if (!attrWeN && !attrCsN) memAttr[attrAddr] <= attrWr;
  end

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // mode encoding used below: 0 standby, 1 byte, 2 word, 3 odd-only
  function automatic logic [1:0] ceBits(int m);
    case (m)
      0: return 2'b11;   // {ce2N, ce1N}
      1: return 2'b10;
      2: return 2'b00;
      default: return 2'b01;
    endcase
  endfunction

  task automatic drive(int m, logic r, logic [HOST_AW-1:0] a, logic o, logic wv, logic [15:0] d, logic wpv);
    logic [1:0] cb;
    cb = ceBits(m);
    ce2N = cb[1]; ce1N = cb[0]; regN = r; addr = a; oeN = o; weN = wv; wrData = d; wp = wpv;
  endtask

  task automatic expRead(int m, logic r, logic [HOST_AW-1:0] a,
                         output logic [17:0] lanes, output logic [NP-1:0] eCsLo,
                         output logic [NP-1:0] eCsHi, output logic eAttrCs);
    int p, w, ai;
    bit a0, uEven, uOdd, eLo, eHi, valid;
    logic [7:0] evenB, oddB;
    a0 = a[0];
    w  = int'(a[DEV_AW:1]);
    p  = int'(a[DEV_AW+1 +: PW]);
    ai = int'(a[ATTR_AW:1]);
    valid = (p < NP);
    uEven = (m == 2) || (m == 1 && !a0);
    uOdd  = (m == 2) || (m == 3) || (m == 1 && a0);
    eLo   = (m == 1) || (m == 2);
    eHi   = (m == 2) || (m == 3);
    if (r) begin
      evenB = valid ? shLo[p*DEPTH+w] : 8'h00;
      oddB  = valid ? shHi[p*DEPTH+w] : 8'h00;
    end else begin
      evenB = shAttr[ai];
      oddB  = 8'hFF;
    end
    lanes = {eLo, eHi, eLo ? ((m == 1 && a0) ? oddB : evenB) : 8'h00, eHi ? oddB : 8'h00};
    eCsLo = '1; eCsHi = '1;
    if (r && valid && uEven) eCsLo[p] = 1'b0;
    if (r && valid && uOdd)  eCsHi[p] = 1'b0;
    eAttrCs = !(!r && uEven);
  endtask

  task automatic readCheck(int m, logic r, logic [HOST_AW-1:0] a, string tag);
    logic [17:0] eLanes, aLanes;
    logic [NP-1:0] eLo, eHi;
    logic eAc;
    @(negedge clk);
    drive(m, r, a, 1'b0, 1'b1, 16'h0000, 1'b0);
    #1;
    expRead(m, r, a, eLanes, eLo, eHi, eAc);
    aLanes = {laneLo, laneHi, eLanes[17] ? rdData[7:0] : 8'h00, eLanes[16] ? rdData[15:8] : 8'h00};
    chk(aLanes == eLanes, tag, "read lanes/data", 64'(aLanes), 64'(eLanes));
    chk({csLoN, csHiN, attrCsN} == {eLo, eHi, eAc},
        (a[HOST_AW-1] ? "R8" : (r ? "R7" : "R9")), "selects",
        64'({csLoN, csHiN, attrCsN}), 64'({eLo, eHi, eAc}));
  endtask

  task automatic writeOp(int m, logic r, logic [HOST_AW-1:0] a, logic [15:0] d, logic wpv, string tag);
    int p, w, ai;
    bit a0, uEven, uOdd;
    logic expDevWe, expAttrWe;
    a0 = a[0];
    w  = int'(a[DEV_AW:1]);
    p  = int'(a[DEV_AW+1 +: PW]);
    ai = int'(a[ATTR_AW:1]);
    uEven = (m == 2) || (m == 1 && !a0);
    uOdd  = (m == 2) || (m == 3) || (m == 1 && a0);
    @(negedge clk);
    drive(m, r, a, 1'b1, 1'b0, d, wpv);
    #1;
    expDevWe  = !(r && !wpv && m != 0);
    expAttrWe = !(!r && uEven);
    chk({devWeN, attrWeN} == {expDevWe, expAttrWe}, tag, "write strobes",
        64'({devWeN, attrWeN}), 64'({expDevWe, expAttrWe}));
    @(negedge clk);
    weN = 1'b1;
    if (r && !wpv && p < NP) begin
      if (uEven) shLo[p*DEPTH+w] = d[7:0];
      if (uOdd)  shHi[p*DEPTH+w] = (m == 1 && a0) ? d[7:0] : d[15:8];
    end
    if (!r && uEven) shAttr[ai] = d[7:0];
    readCheck(2, r, a & ~HOST_AW'(1), tag);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2;
    // reset / idle state R1, R12
    chk({laneLo, laneHi, &csLoN, &csHiN, attrCsN} == 5'b00111, "R1", "idle outputs",
        64'({laneLo, laneHi, &csLoN, &csHiN, attrCsN}), 64'(5'b00111));
    chk(waitN == 1'b1, "R12", "wait idle", 64'(waitN), 64'(1));

    // exhaustive read sweep: both planes, every mode, every address
    for (int r = 1; r >= 0; r--)
      for (int m = 0; m < 4; m++)
        for (int a = 0; a < (1 << HOST_AW); a++)
          readCheck(m, 1'(r), HOST_AW'(a),
                    (r == 0) ? "R9" : (m == 0 ? "R1" : (m == 1 ? "R2" : (m == 2 ? "R3" : "R4"))));

    // R5: no lane without a clean read strobe (OE high, or OE and WE both low)
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        drive(m, 1'b1, HOST_AW'(m * 9), 1'(k == 0), 1'(k != 0 ? 0 : 1), 16'hFFFF, 1'b0);
        #1;
        chk({laneLo, laneHi, devWeN} == 3'b001, "R5", "lanes off without read",
            64'({laneLo, laneHi, devWeN}), 64'(3'b001));
      end
    @(negedge clk);
    drive(0, 1'b1, '0, 1'b1, 1'b1, 16'h0000, 1'b0);

    // flash writes R6, write protect R11
    for (int p = 0; p < 8; p++)
      for (int w = 0; w < DEPTH; w++) begin
        logic [HOST_AW-1:0] base;
        base = HOST_AW'((p << (DEV_AW + 1)) | (w << 1));
        writeOp(2, 1'b1, base, 16'(((p * 16 + w) << 8) | (255 - p * 16 - w)), 1'b0, "R6");
        writeOp(1, 1'b1, base | HOST_AW'(1), 16'(16'h5A00 | 8'(p * 7 + w + 3)), 1'b0, "R6");
        writeOp(1, 1'b1, base, 16'(16'h3300 | 8'(p * 11 + w)), 1'b0, "R6");
        writeOp(3, 1'b1, base, 16'(((p * 13 + w + 1) & 255) << 8 | 16'h00C3), 1'b0, "R6");
        writeOp(2, 1'b1, base, 16'hDEAD, 1'b1, "R11");
      end

    // wrap: write through an aliased address, read through the base R8
    writeOp(2, 1'b1, HOST_AW'(7'b1_001_01_0), 16'hB00C, 1'b0, "R8");
    readCheck(2, 1'b1, HOST_AW'(7'b0_001_01_0), "R8");

    // attribute writes R10
    for (int i = 0; i < ADEPTH; i++) begin
      logic [HOST_AW-1:0] ab;
      ab = HOST_AW'(i << 1);
      writeOp(1, 1'b0, ab, 16'(16'hEE00 | 8'(i * 9 + 1)), 1'b0, "R10");
      writeOp(3, 1'b0, ab, 16'h7777, 1'b0, "R10");
      writeOp(1, 1'b0, ab | HOST_AW'(1), 16'h0044, 1'b0, "R10");
      writeOp(2, 1'b0, ab, 16'(16'h1100 | 8'(i * 5 + 2)), 1'b1, "R10");
    end

    // final full sweep over contents after writes
    for (int r = 1; r >= 0; r--)
      for (int m = 1; m < 4; m++)
        for (int a = 0; a < (1 << HOST_AW); a++)
          readCheck(m, 1'(r), HOST_AW'(a), r == 0 ? "R9" : "R6");

    chk(waitN == 1'b1, "R12", "wait end", 64'(waitN), 64'(1));

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule